// File: doc/BRIEF.md
# Two-Channel Transmit LED Enable Gate

This block turns the transmit inputs of an infrared transceiver into enable signals for two LED drivers: one for the data-link LED and one for the remote-control LED. A strap chooses between two drive modes. In dual mode each channel has its own transmit input. In single mode one input serves both channels, and the mode already latched by the mode-programming logic picks which LED it reaches. A shutdown input forces everything dark. The block also registers a current-range select for the data-link LED from the current bandwidth mode.

Each channel carries an on-time guard. This counter turns the LED off once its request has been held for a fixed number of cycles, which corresponds to 50 µs at the configured clock. The channel stays dark until the request drops. All outputs are registered, so every output follows its inputs by exactly one clock. An active-low asynchronous reset is released through a two-stage synchronizer, so the block starts two clocks after reset is released.

Top module: `led_drive_gate`

## Requirements
- R1: While reset is asserted, and for the two clocks after it is released, all outputs are 0.
- R2: In dual mode (`dual_drive`=1) with `shutdown`=0, outputs follow the inputs one clock later. The input pair (`tx_ir`,`tx_rc`)=(0,0) gives both enables 0. (1,0) gives only `ir_led_en`=1. (0,1) gives only `rc_led_en`=1.
- R3: In dual mode with `shutdown`=0, both transmit inputs high gives both enables 0 and `conflict`=1 one clock later. `conflict` is 0 in every other case.
- R4: With `shutdown`=1, the next clock shows both enables, both timeout flags, `conflict` and `ir_hi_range` at 0, whatever the other inputs are.
- R5: In single mode (`dual_drive`=0) with `shutdown`=0, `tx_ir` drives `rc_led_en` when `rc_mode`=1 and `ir_led_en` when `rc_mode`=0. `tx_rc` has no effect on any output.
- R6: With `shutdown`=0, `ir_hi_range` equals `mir_fir_mode` from one clock earlier. A value of 1 selects the high current range (MIR/FIR, about 150 mA). A value of 0 selects the low range (SIR, about 65 mA).
- R7: While a channel's request is held, its enable stays high for exactly `TIMEOUT_CYC` clocks, where `TIMEOUT_CYC` = `CLK_MHZ`*`MAX_ON_NS`/1000. From the next clock on, the enable is 0 and that channel's timeout flag is 1 for as long as the request is held.
- R8: When a channel's request is low for one clock, its timeout flag clears on the following clock and its counter clears. A new request then gets a full `TIMEOUT_CYC`-clock window again.
- R9: `ir_led_en` and `rc_led_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ir | input | 1 | Data-link transmit input (the shared input in single mode) |
| tx_rc | input | 1 | Remote-control transmit input (used in dual mode only) |
| shutdown | input | 1 | Forces every output low |
| dual_drive | input | 1 | Strap: 1 = dual-input drive, 0 = single-input drive |
| rc_mode | input | 1 | Latched mode: 1 = single input steers to remote-control LED |
| mir_fir_mode | input | 1 | Bandwidth mode: 1 = MIR/FIR, 0 = SIR |
| ir_led_en | output | 1 | Data-link LED driver enable |
| rc_led_en | output | 1 | Remote-control LED driver enable |
| ir_hi_range | output | 1 | Data-link LED current range: 1 = high, 0 = low |
| ir_timeout | output | 1 | Data-link channel stopped by on-time guard |
| rc_timeout | output | 1 | Remote-control channel stopped by on-time guard |
| conflict | output | 1 | Both inputs high in dual mode |

## Verification
The hardest states to reach from the ports are the two edges of the on-time guard. The first is the clock where the enable falls while the request is still held. The second is the one-clock drop that re-arms the channel. The bench uses a short on-time limit so that it can hold each request, check the outputs every clock across the whole window and past its end, drop the request for a single clock, and confirm that a full new window follows. This is repeated for both channels in dual mode and for the remote-control path in single mode. All 64 static input combinations are also swept, each starting from a cleared counter.

// File: rtl/led_gate_pkg.sv
package led_gate_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_IR  = 0;
  localparam int unsigned CH_RC  = 1;
  typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/led_gate_rst_sync.sv
module led_gate_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/led_gate_route.sv
module led_gate_route
  import led_gate_pkg::*;
(
  input  logic    tx_ir,
  input  logic    tx_rc,
  input  logic    shutdown,
  input  logic    dual_drive,
  input  logic    rc_mode,
  output ch_vec_t req,
  output logic    conflict
);
  always_comb begin
    req      = '0;
    conflict = 1'b0;
    if (!shutdown) begin
      if (dual_drive) begin
        conflict   = tx_ir & tx_rc;
        req[CH_IR] = tx_ir & ~tx_rc;
        req[CH_RC] = tx_rc & ~tx_ir;
      end else begin
        req[CH_IR] = tx_ir & ~rc_mode;
        req[CH_RC] = tx_ir & rc_mode;
      end
    end
  end
endmodule

// File: rtl/led_gate_guard.sv
module led_gate_guard #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             exp_q, exp_d;
  logic             at_lim;

  assign at_lim = (cnt_q == LIM);

  always_comb begin
    if (!req)        cnt_d = '0;
    else if (at_lim) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
    en_d  = req & ~at_lim;
    exp_d = req & at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
      exp_q <= exp_d;
    end
  end

  assign en      = en_q;
  assign expired = exp_q;
endmodule

// File: rtl/led_drive_gate.sv
module led_drive_gate
  import led_gate_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 200,
  parameter int unsigned MAX_ON_NS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ir,
  input  logic tx_rc,
  input  logic shutdown,
  input  logic dual_drive,
  input  logic rc_mode,
  input  logic mir_fir_mode,
  output logic ir_led_en,
  output logic rc_led_en,
  output logic ir_hi_range,
  output logic ir_timeout,
  output logic rc_timeout,
  output logic conflict
);
  localparam int unsigned TIMEOUT_CYC = CLK_MHZ * MAX_ON_NS / 1000;

  logic    srst_n;
  ch_vec_t req;
  ch_vec_t en_vec;
  ch_vec_t exp_vec;
  logic    conflict_c;
  logic    conflict_q;
  logic    hi_q, hi_d;

  led_gate_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  led_gate_route u_route (
    .tx_ir      (tx_ir),
    .tx_rc      (tx_rc),
    .shutdown   (shutdown),
    .dual_drive (dual_drive),
    .rc_mode    (rc_mode),
    .req        (req),
    .conflict   (conflict_c)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    led_gate_guard #(.LIMIT(TIMEOUT_CYC)) u_guard (
      .clk     (clk),
      .rst_n   (srst_n),
      .req     (req[g]),
      .en      (en_vec[g]),
      .expired (exp_vec[g])
    );
  end

  assign hi_d = ~shutdown & mir_fir_mode;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      conflict_q <= 1'b0;
      hi_q       <= 1'b0;
    end else begin
      conflict_q <= conflict_c;
      hi_q       <= hi_d;
    end
  end

  assign ir_led_en   = en_vec[CH_IR];
  assign rc_led_en   = en_vec[CH_RC];
  assign ir_timeout  = exp_vec[CH_IR];
  assign rc_timeout  = exp_vec[CH_RC];
  assign conflict    = conflict_q;
  assign ir_hi_range = hi_q;
endmodule

// File: rtl/led_drive_gate_chk.sv
module led_drive_gate_chk #(
  parameter int unsigned LIMIT = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_ir,
  input logic tx_rc,
  input logic shutdown,
  input logic dual_drive,
  input logic mir_fir_mode,
  input logic ir_led_en,
  input logic rc_led_en,
  input logic ir_hi_range,
  input logic ir_timeout,
  input logic rc_timeout,
  input logic conflict
);
  localparam int unsigned RW = $clog2(LIMIT + 2);
  localparam logic [RW-1:0] LIM = RW'(LIMIT);

  logic [RW-1:0] ir_run_q, rc_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_run_q <= '0;
      rc_run_q <= '0;
    end else begin
      ir_run_q <= !ir_led_en ? '0 : (ir_run_q > LIM ? ir_run_q : ir_run_q + 1'b1);
      rc_run_q <= !rc_led_en ? '0 : (rc_run_q > LIM ? rc_run_q : rc_run_q + 1'b1);
    end
  end

  p_sd_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!ir_led_en && !rc_led_en && !conflict && !ir_timeout && !rc_timeout && !ir_hi_range));

  p_conflict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_drive && !shutdown && tx_ir && tx_rc) |=> (conflict && !ir_led_en && !rc_led_en));

  p_single_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_drive && !tx_ir) |=> (!ir_led_en && !rc_led_en && !conflict));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |=> (ir_hi_range == $past(mir_fir_mode)));

  p_ir_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ir_led_en |-> (ir_run_q < LIM));

  p_rc_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rc_led_en |-> (rc_run_q < LIM));

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ir && !tx_rc) |=> (!ir_timeout && !rc_timeout));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_led_en && rc_led_en));
endmodule

bind led_drive_gate led_drive_gate_chk #(.LIMIT(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (srst_n),
  .tx_ir        (tx_ir),
  .tx_rc        (tx_rc),
  .shutdown     (shutdown),
  .dual_drive   (dual_drive),
  .mir_fir_mode (mir_fir_mode),
  .ir_led_en    (ir_led_en),
  .rc_led_en    (rc_led_en),
  .ir_hi_range  (ir_hi_range),
  .ir_timeout   (ir_timeout),
  .rc_timeout   (rc_timeout),
  .conflict     (conflict)
);

// File: tb/led_drive_gate_bench.sv
module led_drive_gate_bench;
  localparam int unsigned CLK_MHZ   = 200;
  localparam int unsigned MAX_ON_NS = 100;
  localparam int unsigned LIM       = CLK_MHZ * MAX_ON_NS / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_ir = 1'b0, tx_rc = 1'b0, shutdown = 1'b0, dual_drive = 1'b0;
  logic rc_mode = 1'b0, mir_fir_mode = 1'b0;
  logic ir_led_en, rc_led_en, ir_hi_range, ir_timeout, rc_timeout, conflict;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  led_drive_gate #(.CLK_MHZ(CLK_MHZ), .MAX_ON_NS(MAX_ON_NS)) u_led_drive_gate (
    .clk, .rst_n, .tx_ir, .tx_rc, .shutdown, .dual_drive, .rc_mode,
    .mir_fir_mode, .ir_led_en, .rc_led_en, .ir_hi_range, .ir_timeout,
    .rc_timeout, .conflict
  );

  function automatic logic [5:0] outs();
    return {ir_led_en, rc_led_en, conflict, ir_hi_range, ir_timeout, rc_timeout};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b (ir_en rc_en conf hi ir_to rc_to)", req, act, exp);
    end
  endtask

  // expected outputs for a fresh (counter cleared) cycle
  function automatic logic [5:0] model(input logic sd, input logic dm, input logic rm,
                                       input logic mf, input logic ti, input logic tr);
    logic ie, re, cf, hi;
    ie = 0; re = 0; cf = 0; hi = 0;
    if (!sd) begin
      hi = mf;
      if (dm) begin
        cf = ti & tr;
        ie = ti & ~tr;
        re = tr & ~ti;
      end else begin
        ie = ti & ~rm;
        re = ti & rm;
      end
    end
    return {ie, re, cf, hi, 1'b0, 1'b0};
  endfunction

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // hold a request and walk the whole window; sel: 0 = ir channel, 1 = rc channel
  task automatic window_test(input string tag, input bit sel);
    logic [5:0] on_v, off_v;
    on_v  = sel ? 6'b010000 : 6'b100000;
    off_v = sel ? 6'b000001 : 6'b000010;
    for (int k = 1; k <= int'(LIM) + 3; k++) begin
      @(negedge clk);
      chk(tag, outs(), (k <= int'(LIM)) ? on_v : off_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset and synchronizer release
    tx_ir = 1; dual_drive = 1; mir_fir_mode = 1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 6'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", outs(), 6'b0);
    tx_ir = 0; dual_drive = 0; mir_fir_mode = 0;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R6: exhaustive static sweep
    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      b = 6'(v);
      tx_ir = 0; tx_rc = 0;
      @(negedge clk);
      {shutdown, dual_drive, rc_mode, mir_fir_mode, tx_ir, tx_rc} = b;
      @(negedge clk);
      chk(b[5] ? "R4 shutdown" : (b[4] ? (b[1] & b[0] ? "R3 conflict" : "R2 dual route")
                                       : "R5 single route, R6 range"),
          outs(), model(b[5], b[4], b[3], b[2], b[1], b[0]));
    end
    shutdown = 0; tx_ir = 0; tx_rc = 0; mir_fir_mode = 0;
    @(negedge clk);

    // R7 R8: ir channel in dual mode
    dual_drive = 1; tx_ir = 1;
    window_test("R7 ir window", 0);
    tx_ir = 0;
    @(negedge clk);
    chk("R8 ir clear", outs(), 6'b0);
    tx_ir = 1;
    window_test("R8 ir rearm", 0);
    tx_ir = 0;
    @(negedge clk);

    // R7 R8: rc channel in dual mode
    tx_rc = 1;
    window_test("R7 rc window", 1);
    tx_rc = 0;
    @(negedge clk);
    chk("R8 rc clear", outs(), 6'b0);
    tx_rc = 1;
    window_test("R8 rc rearm", 1);
    tx_rc = 0;
    @(negedge clk);

    // R5 R7: rc path in single mode via tx_ir, tx_rc toggling has no effect
    dual_drive = 0; rc_mode = 1; tx_ir = 1;
    for (int k = 1; k <= int'(LIM) + 2; k++) begin
      tx_rc = k[0];
      @(negedge clk);
      chk("R5 R7 single rc window", outs(), (k <= int'(LIM)) ? 6'b010000 : 6'b000001);
    end
    tx_ir = 0; tx_rc = 0;
    @(negedge clk);
    chk("R8 single clear", outs(), 6'b0);

    // R4: shutdown mid-window clears a running channel
    rc_mode = 0; tx_ir = 1;
    repeat (3) @(negedge clk);
    chk("R2 single ir on", outs(), 6'b100000);
    shutdown = 1;
    @(negedge clk);
    chk("R4 shutdown mid-window", outs(), 6'b0);
    shutdown = 0;
    @(negedge clk);
    chk("R8 rearm after shutdown", outs(), 6'b100000);
    tx_ir = 0;
    @(negedge clk);

    summary();
  end
endmodule